// File: doc/BRIEF.md
# Legacy Interrupt Controller Programming Front End

This block is the register sequencer for a cascaded pair of legacy x86 interrupt controllers. The primary unit serves request lines 0 to 7 and the secondary unit serves lines 8 to 15. The CPU reaches the block through 8-bit I/O writes and reads. Each unit owns an even port and an odd port. Even-port writes are decoded into the restart word or into one of two operation words. Odd-port writes are consumed by the initialization sequence first, and after that they load the interrupt mask.

The block holds the configuration that the priority logic downstream needs: an initialized flag, the vector base, the mask, the special-fully-nested flag and a sticky configuration-error flag. It also returns read data. Odd-port reads give the mask. Even-port reads give the pending-request or in-service vector, both supplied from outside, as chosen by the last read-select command. The subset supported is cascade mode, normal end-of-interrupt and x86 mode only. Priority resolution, acknowledge cycles, in-service tracking and end-of-interrupt handling are out of scope.

Top module: `irq_prog_front`

## Requirements
- R1: After reset, both units are uninitialized (ready=0), masks are FFh, vector bases are 0, the nested flags and error flags are 0, and the read select is the pending-request vector.
- R2: Ports 20h (even) and 21h (odd) address the primary unit, and A0h (even) and A1h (odd) address the secondary unit. Accesses to any other address change no output.
- R3: An even-port write with data bit 4 = 1 always restarts that unit. It clears ready, sets the read select to the pending-request vector and leaves the mask as it is. The next three odd-port writes are then taken as the second, third and fourth initialization words, in that order.
- R4: Bits [7:3] of the second initialization word are latched as that unit's vector base. Bits [2:0] are ignored.
- R5: The third initialization word must equal 04h on the primary unit and 02h on the secondary unit. Any other value sets that unit's error flag, which stays set until reset, and the sequence still advances.
- R6: In the restart word, bit 1 = 1 (single mode) or bit 0 = 0 (fourth word not needed) sets the error flag. Bits 7:5, 3 and 2 have no effect.
- R7: Bit 4 of the fourth initialization word is latched as the special-fully-nested flag and the unit becomes ready. The word's other bits have no effect.
- R8: An odd-port write while the unit is ready loads the mask with the full data byte. An odd-port write while the unit is uninitialized has no effect.
- R9: An even-port write with data bits [4:3] = 00 (end-of-interrupt command) changes no output.
- R10: An even-port write with data bits [4:3] = 01 and bit 1 = 1 sets the read select from bit 0 (0 = pending-request, 1 = in-service). With bit 1 = 0 the select is kept.
- R11: `io_rdata` updates on the clock edge that samples `io_rd` and holds its value otherwise. An odd-port read returns the mask, an even-port read returns the selected external vector, and an unmapped read returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| pri_irr | input | 8 | Primary pending-request vector |
| pri_isr | input | 8 | Primary in-service vector |
| sec_irr | input | 8 | Secondary pending-request vector |
| sec_isr | input | 8 | Secondary in-service vector |
| pri_ready | output | 1 | Primary initialization complete |
| sec_ready | output | 1 | Secondary initialization complete |
| pri_vbase | output | 5 | Primary vector base (bits 7:3 of vector) |
| sec_vbase | output | 5 | Secondary vector base |
| pri_mask | output | 8 | Primary interrupt mask |
| sec_mask | output | 8 | Secondary interrupt mask |
| pri_nested | output | 1 | Primary special-fully-nested flag |
| sec_nested | output | 1 | Secondary special-fully-nested flag |
| pri_cfg_err | output | 1 | Primary sticky configuration error |
| sec_cfg_err | output | 1 | Secondary sticky configuration error |

## Verification
The bench goes after a restart word that arrives in the middle of a sequence. A design that did not restart would take the next odd write as a mask instead of a vector base. It checks odd writes before any restart word, which a careless design would load into the mask. It also checks wrong cascade values, where a design that stalled the sequence or dropped the error flag would never become ready or would hide the misconfiguration. Read-select commands with bit 1 clear, end-of-interrupt words and near-miss addresses such as 22h or A2h are mixed into random traffic, so a design that decoded too few address bits or always took bit 0 would return the wrong vector.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RUN  = 3'd4
  } seq_t;

  typedef struct packed {
    logic       ready;
    logic [4:0] vbase;
    logic [7:0] mask;
    logic       nested;
    logic       err;
    logic       rsel_isr;
  } unit_cfg_t;
endpackage

// File: rtl/irqp_decode.sv
module irqp_decode #(
  parameter int AW = 8,
  parameter int NUNIT = 2,
  parameter logic [AW-1:0] PRI_BASE = 8'h20,
  parameter logic [AW-1:0] SEC_BASE = 8'hA0,
  localparam int UW = (NUNIT > 1) ? $clog2(NUNIT) : 1
) (
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [AW-1:0]    io_addr,
  output logic [NUNIT-1:0] wr_even,
  output logic [NUNIT-1:0] wr_odd,
  output logic             rd_hit,
  output logic [UW-1:0]    rd_unit,
  output logic             rd_odd
);
  localparam logic [1:0][AW-1:0] BASES = {SEC_BASE, PRI_BASE};

  logic [NUNIT-1:0] hit;

  for (genvar g = 0; g < NUNIT; g++) begin : g_hit
    assign hit[g]     = (io_addr[AW-1:1] == BASES[g][AW-1:1]);
    assign wr_even[g] = io_wr & hit[g] & ~io_addr[0];
    assign wr_odd[g]  = io_wr & hit[g] &  io_addr[0];
  end

  always_comb begin
    rd_unit = '0;
    for (int i = 0; i < NUNIT; i++) begin
      if (hit[i]) rd_unit = UW'(i);
    end
  end

  assign rd_hit = io_rd & (|hit);
  assign rd_odd = io_addr[0];
endmodule

// File: rtl/irqp_unit.sv
module irqp_unit
  import irqp_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] CASCADE_REQ = 8'h04
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_even,
  input  logic          wr_odd,
  input  logic [DW-1:0] wdata,
  output unit_cfg_t     cfg
);
  seq_t       st_q;
  logic [4:0] vbase_q;
  logic [7:0] mask_q;
  logic       nested_q, err_q, rsel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      vbase_q  <= '0;
      mask_q   <= '1;
      nested_q <= 1'b0;
      err_q    <= 1'b0;
      rsel_q   <= 1'b0;
    end else if (wr_even) begin
      if (wdata[4]) begin
        // restart word: mode bits checked, others ignored
        st_q   <= ST_W2;
        rsel_q <= 1'b0;
        if (wdata[1] || !wdata[0]) err_q <= 1'b1;
      end else if (wdata[3] && wdata[1]) begin
        // read-select command
        rsel_q <= wdata[0];
      end
      // bits[4:3]=00: end-of-interrupt command, no effect here
    end else if (wr_odd) begin
      unique case (st_q)
        ST_W2: begin
          vbase_q <= wdata[7:3];
          st_q    <= ST_W3;
        end
        ST_W3: begin
          if (wdata != CASCADE_REQ) err_q <= 1'b1;
          st_q <= ST_W4;
        end
        ST_W4: begin
          nested_q <= wdata[4];
          st_q     <= ST_RUN;
        end
        ST_RUN:  mask_q <= wdata;
        default: ;
      endcase
    end
  end

  assign cfg.ready    = (st_q == ST_RUN);
  assign cfg.vbase    = vbase_q;
  assign cfg.mask     = mask_q;
  assign cfg.nested   = nested_q;
  assign cfg.err      = err_q;
  assign cfg.rsel_isr = rsel_q;

  // R3
  icw_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_even && wdata[4]) |=> (!cfg.ready && !cfg.rsel_isr));
  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_odd && cfg.ready) |=> (cfg.mask == $past(wdata)));
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_odd && cfg.ready) |=> $stable(cfg.mask));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg.err |=> cfg.err);
  // R9
  eoi_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_even && wdata[4:3] == 2'b00) |=> ($stable(cfg.rsel_isr) && $stable(cfg.ready)));
endmodule

// File: rtl/irqp_rdmux.sv
module irqp_rdmux #(
  parameter int DW = 8,
  parameter int NUNIT = 2,
  localparam int UW = (NUNIT > 1) ? $clog2(NUNIT) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_hit,
  input  logic                      io_rd,
  input  logic [UW-1:0]             rd_unit,
  input  logic                      rd_odd,
  input  logic [NUNIT-1:0][DW-1:0]  mask,
  input  logic [NUNIT-1:0][DW-1:0]  irr,
  input  logic [NUNIT-1:0][DW-1:0]  isr,
  input  logic [NUNIT-1:0]          rsel_isr,
  output logic [DW-1:0]             rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    if (!rd_hit)                sel = '0;
    else if (rd_odd)            sel = mask[rd_unit];
    else if (rsel_isr[rd_unit]) sel = isr[rd_unit];
    else                        sel = irr[rd_unit];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (io_rd) rdata <= sel;
  end

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(rdata));
  // R11
  rd_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !rd_hit) |=> (rdata == '0));
endmodule

// File: rtl/irq_prog_front.sv
module irq_prog_front
  import irqp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] PRI_BASE = 8'h20,
  parameter logic [AW-1:0] SEC_BASE = 8'hA0,
  parameter logic [DW-1:0] PRI_CASCADE = 8'h04,
  parameter logic [DW-1:0] SEC_CASCADE = 8'h02
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic [DW-1:0] pri_irr,
  input  logic [DW-1:0] pri_isr,
  input  logic [DW-1:0] sec_irr,
  input  logic [DW-1:0] sec_isr,
  output logic          pri_ready,
  output logic          sec_ready,
  output logic [4:0]    pri_vbase,
  output logic [4:0]    sec_vbase,
  output logic [DW-1:0] pri_mask,
  output logic [DW-1:0] sec_mask,
  output logic          pri_nested,
  output logic          sec_nested,
  output logic          pri_cfg_err,
  output logic          sec_cfg_err
);
  localparam int NUNIT = 2;
  localparam int UW = 1;
  localparam logic [1:0][DW-1:0] CASC = {SEC_CASCADE, PRI_CASCADE};

  logic [NUNIT-1:0] wr_even, wr_odd, rsel;
  logic             rd_hit, rd_odd;
  logic [UW-1:0]    rd_unit;
  unit_cfg_t        cfg [NUNIT];
  logic [NUNIT-1:0][DW-1:0] mask_v, irr_v, isr_v;

  irqp_decode #(.AW(AW), .NUNIT(NUNIT), .PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE)) u_dec (
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .wr_even(wr_even), .wr_odd(wr_odd),
    .rd_hit(rd_hit), .rd_unit(rd_unit), .rd_odd(rd_odd)
  );

  for (genvar g = 0; g < NUNIT; g++) begin : g_unit
    irqp_unit #(.DW(DW), .CASCADE_REQ(CASC[g])) u_unit (
      .clk(clk), .rst(rst),
      .wr_even(wr_even[g]), .wr_odd(wr_odd[g]),
      .wdata(io_wdata), .cfg(cfg[g])
    );
    assign mask_v[g] = cfg[g].mask;
    assign rsel[g]   = cfg[g].rsel_isr;
  end

  assign irr_v = {sec_irr, pri_irr};
  assign isr_v = {sec_isr, pri_isr};

  irqp_rdmux #(.DW(DW), .NUNIT(NUNIT)) u_rd (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .io_rd(io_rd),
    .rd_unit(rd_unit), .rd_odd(rd_odd),
    .mask(mask_v), .irr(irr_v), .isr(isr_v), .rsel_isr(rsel),
    .rdata(io_rdata)
  );

  assign pri_ready   = cfg[0].ready;
  assign sec_ready   = cfg[1].ready;
  assign pri_vbase   = cfg[0].vbase;
  assign sec_vbase   = cfg[1].vbase;
  assign pri_mask    = cfg[0].mask;
  assign sec_mask    = cfg[1].mask;
  assign pri_nested  = cfg[0].nested;
  assign sec_nested  = cfg[1].nested;
  assign pri_cfg_err = cfg[0].err;
  assign sec_cfg_err = cfg[1].err;

  // R2
  addr_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr[AW-1:1] != PRI_BASE[AW-1:1] && io_addr[AW-1:1] != SEC_BASE[AW-1:1])
    |=> ($stable(pri_mask) && $stable(sec_mask) && $stable(pri_ready) && $stable(sec_ready)));
endmodule

// File: tb/sim_irq_prog_front.sv
module sim_irq_prog_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic [7:0] io_rdata;
  logic [7:0] pri_irr = '0, pri_isr = '0, sec_irr = '0, sec_isr = '0;
  logic       pri_ready, sec_ready, pri_nested, sec_nested, pri_cfg_err, sec_cfg_err;
  logic [4:0] pri_vbase, sec_vbase;
  logic [7:0] pri_mask, sec_mask;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model
  int         m_st [2];
  logic [4:0] m_vb [2];
  logic [7:0] m_mask [2];
  logic       m_nest [2], m_err [2], m_rsel [2];
  logic [7:0] m_rdata;
  logic [7:0] casc [2] = '{8'h04, 8'h02};

  always #2.5 clk = ~clk;

  irq_prog_front u0 (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pri_irr(pri_irr), .pri_isr(pri_isr), .sec_irr(sec_irr), .sec_isr(sec_isr),
    .pri_ready(pri_ready), .sec_ready(sec_ready),
    .pri_vbase(pri_vbase), .sec_vbase(sec_vbase),
    .pri_mask(pri_mask), .sec_mask(sec_mask),
    .pri_nested(pri_nested), .sec_nested(sec_nested),
    .pri_cfg_err(pri_cfg_err), .sec_cfg_err(sec_cfg_err)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int unit_of(logic [7:0] a);
    if (a[7:1] == 7'h10) return 0;
    if (a[7:1] == 7'h50) return 1;
    return -1;
  endfunction

  task automatic mdl_reset();
    for (int u = 0; u < 2; u++) begin
      m_st[u] = 0; m_vb[u] = '0; m_mask[u] = 8'hFF;
      m_nest[u] = 0; m_err[u] = 0; m_rsel[u] = 0;
    end
    m_rdata = '0;
  endtask

  task automatic mdl_write(logic [7:0] a, logic [7:0] d);
    int u;
    u = unit_of(a);
    if (u < 0) return;
    if (!a[0]) begin
      if (d[4]) begin
        m_st[u] = 1; m_rsel[u] = 0;
        if (d[1] || !d[0]) m_err[u] = 1;
      end else if (d[4:3] == 2'b01 && d[1]) m_rsel[u] = d[0];
    end else begin
      case (m_st[u])
        1: begin m_vb[u] = d[7:3]; m_st[u] = 2; end
        2: begin if (d != casc[u]) m_err[u] = 1; m_st[u] = 3; end
        3: begin m_nest[u] = d[4]; m_st[u] = 4; end
        4: m_mask[u] = d;
        default: ;
      endcase
    end
  endtask

  function automatic logic [7:0] mdl_read(logic [7:0] a);
    int u;
    u = unit_of(a);
    if (u < 0) return 8'h00;
    if (a[0]) return m_mask[u];
    if (u == 0) return m_rsel[0] ? pri_isr : pri_irr;
    return m_rsel[1] ? sec_isr : sec_irr;
  endfunction

  task automatic check_all(string ctx);
    chk({ctx, " R7 pri_ready"}, {7'b0, pri_ready}, {7'b0, m_st[0] == 4});
    chk({ctx, " R7 sec_ready"}, {7'b0, sec_ready}, {7'b0, m_st[1] == 4});
    chk({ctx, " R4 pri_vbase"}, {3'b0, pri_vbase}, {3'b0, m_vb[0]});
    chk({ctx, " R4 sec_vbase"}, {3'b0, sec_vbase}, {3'b0, m_vb[1]});
    chk({ctx, " R8 pri_mask"}, pri_mask, m_mask[0]);
    chk({ctx, " R8 sec_mask"}, sec_mask, m_mask[1]);
    chk({ctx, " R7 pri_nested"}, {7'b0, pri_nested}, {7'b0, m_nest[0]});
    chk({ctx, " R7 sec_nested"}, {7'b0, sec_nested}, {7'b0, m_nest[1]});
    chk({ctx, " R5 pri_err"}, {7'b0, pri_cfg_err}, {7'b0, m_err[0]});
    chk({ctx, " R5 sec_err"}, {7'b0, sec_cfg_err}, {7'b0, m_err[1]});
    chk({ctx, " R11 rdata"}, io_rdata, m_rdata);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string ctx);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    mdl_write(a, d);
    check_all(ctx);
  endtask

  task automatic rd(logic [7:0] a, string ctx);
    io_addr = a; io_rd = 1'b1;
    m_rdata = mdl_read(a);
    @(negedge clk);
    io_rd = 1'b0;
    check_all(ctx);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mdl_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    do_reset();
    // R1 reset state
    check_all("R1 reset");
    pri_irr = 8'h5A; pri_isr = 8'hC3; sec_irr = 8'h81; sec_isr = 8'h3C;
    rd(8'h20, "R1 reset read-select IRR");
    rd(8'hA1, "R1 reset mask read");

    // R8: odd write before init ignored
    wr(8'h21, 8'h00, "R8 uninit odd write");
    // R2: near-miss addresses
    wr(8'h22, 8'h11, "R2 miss 22h");
    wr(8'hA3, 8'h00, "R2 miss A3h");
    rd(8'h40, "R2 R11 unmapped read");

    // primary init, ICW2 low bits ignored
    wr(8'h20, 8'hF1, "R3 R6 icw1 ignored bits");
    wr(8'h21, 8'h0F, "R4 icw2");
    wr(8'h21, 8'h04, "R5 icw3 good");
    wr(8'h21, 8'h0F, "R7 icw4 others ignored");
    wr(8'h21, 8'hA5, "R8 mask load");
    rd(8'h21, "R11 mask read");
    // secondary init with wrong cascade
    wr(8'hA0, 8'h11, "R3 sec icw1");
    wr(8'hA1, 8'h70, "R4 sec icw2");
    wr(8'hA1, 8'h04, "R5 sec bad icw3");
    wr(8'hA1, 8'h10, "R7 sec icw4 nested");
    wr(8'hA1, 8'h3C, "R8 sec mask");
    // R10 read select
    wr(8'h20, 8'h0B, "R10 select ISR");
    rd(8'h20, "R10 read ISR");
    wr(8'h20, 8'h08, "R10 bit1 clear keeps");
    rd(8'h20, "R10 still ISR");
    // R9 end-of-interrupt word
    wr(8'h20, 8'h20, "R9 eoi word");
    wr(8'hA0, 8'h67, "R9 eoi word sec");
    // R3 restart mid-sequence
    wr(8'h20, 8'h11, "R3 restart");
    wr(8'h21, 8'h48, "R3 icw2 after restart");
    wr(8'h20, 8'h11, "R3 restart again");
    wr(8'h21, 8'h90, "R3 taken as icw2");

    // R6 on fresh reset
    do_reset();
    wr(8'h20, 8'h13, "R6 single mode flagged");
    wr(8'hA0, 8'h10, "R6 no icw4 flagged");

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] a, d;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: a = 8'h21;
        3, 4:    a = 8'hA1;
        5:       a = 8'h20;
        6:       a = 8'hA0;
        default: a = 8'($urandom);
      endcase
      d = 8'($urandom);
      if (!a[0] && unit_of(a) >= 0) begin
        case ($urandom_range(0, 3))
          0: d = ($urandom_range(0, 3) != 0) ? 8'h11 : (d | 8'h10);
          1: d = d & 8'hE7;
          default: d = (d & 8'h67) | 8'h08;
        endcase
      end else if (a[0] && $urandom_range(0, 2) == 0) begin
        d = casc[unit_of(a) == 1 ? 1 : 0];
      end
      pri_irr = 8'($urandom); pri_isr = 8'($urandom);
      sec_irr = 8'($urandom); sec_isr = 8'($urandom);
      if ($urandom_range(0, 2) == 0) rd(a, "rand read R11");
      else wr(a, d, "rand write R2 R9 R10");
      if ($urandom_range(0, 50) == 0) begin
        do_reset();
        check_all("R1 rand reset");
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule